// File: doc/BRIEF.md
# Halt Mode Power Sequencer

This block takes a small microcontroller into its deepest sleep state and brings it back out. When the core signals a halt instruction, the sequencer checks the configuration. It then either stops the oscillator and gates every clock, or turns the request into a watchdog reset, or ignores the request. While the part is halted, only a reset request or an interrupt from a configurable wake-capable subset can start the way back.

On wake, the oscillator enable returns at once. A stabilization delay of 256 or 4096 clock cycles is then counted on the free-running oscillator clock. Core and peripheral clocks stay gated until that delay has run out. If the PLL is in use, they also wait for the PLL to report lock. At release the block reports why the part woke: either a reset, so the core fetches the reset vector, or the masked interrupt vector that the core must service. The interrupt mask override is held while halted, so a wake-capable interrupt that is already pending ends the halt after a single cycle.

Top module: `halt_pwr_seq`

## Requirements
- R1: After reset, osc_en, cpu_clk_en and per_clk_en are 1, while imask_clr, wdg_rst and wake_valid are 0. A one-cycle halt_req while running is ignored if cfg_active_halt=1 or cfg_awu_en=1. When ignored, all outputs stay unchanged and no wdg_rst pulse is produced.
- R2: A qualified halt_req with cfg_wdg_en=1 and cfg_wdg_halt_ok=0 does not halt. Instead, wdg_rst is 1 for exactly one cycle, starting the cycle after the request, and all clock enables stay 1.
- R3: A qualified halt_req that is not turned into a watchdog reset drives osc_en, cpu_clk_en and per_clk_en to 0 from the next cycle. imask_clr is 1 in every cycle in which osc_en is 0.
- R4: If a wake-capable interrupt is already asserted when halt is entered, osc_en is 0 for exactly one cycle.
- R5: While halted, only reset_req or an irq_req bit whose WAKE_MASK bit is set wakes the part. The default WAKE_MASK is 4'b0101, so bits 0 and 2 can wake. All other interrupt bits leave osc_en at 0.
- R6: osc_en returns to 1 in the cycle after the wake source is seen. With cfg_pll_en=0, cpu_clk_en and per_clk_en return to 1 exactly 256 cycles after osc_en rises when cfg_long_dly=0, and exactly 4096 cycles after when cfg_long_dly=1.
- R7: With cfg_pll_en=1, release is withheld for as long as pll_locked is 0. Release then occurs one cycle after pll_locked rises, or at the normal delay end if pll_locked is already 1.
- R8: wake_valid is a one-cycle pulse in the first cycle in which per_clk_en is back to 1. For a reset wake, wake_is_reset=1 and wake_irq=0. For an interrupt wake, wake_is_reset=0 and wake_irq equals irq_req AND WAKE_MASK as sampled at wake.
- R9: If reset_req and a wake-capable interrupt arrive in the same cycle, the wake is reported as a reset: wake_is_reset=1 and wake_irq=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | One-cycle halt instruction strobe from the core |
| cfg_active_halt | input | 1 | Active-halt mode selected (blocks deep halt) |
| cfg_awu_en | input | 1 | Auto-wakeup enabled (blocks deep halt) |
| cfg_wdg_en | input | 1 | Watchdog running |
| cfg_wdg_halt_ok | input | 1 | 1 = halt allowed with watchdog running |
| cfg_long_dly | input | 1 | 0 = 256-cycle, 1 = 4096-cycle stabilization |
| cfg_pll_en | input | 1 | PLL in use, wait for lock before release |
| pll_locked | input | 1 | PLL lock indication |
| reset_req | input | 1 | Reset request (wake source) |
| irq_req | input | NIRQ | Interrupt request vector |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| imask_clr | output | 1 | Forces the core interrupt mask clear |
| wdg_rst | output | 1 | One-cycle watchdog reset pulse |
| wake_valid | output | 1 | One-cycle pulse at clock release after a wake |
| wake_is_reset | output | 1 | Last wake came from reset (fetch reset vector) |
| wake_irq | output | NIRQ | Masked interrupts that caused the last wake |

## Verification
The bench goes after the halt qualification matrix. A design that decoded the blocking bits or the watchdog option wrongly would halt when it must not, or would halt instead of pulsing wdg_rst. It measures the stabilization delay to the exact cycle for both lengths, where an off-by-one counter load would show up as 255 or 257. It also checks that a pending interrupt at entry gives a single halted cycle, because a design that ignored pending requests would sleep on. Finally, it drives a non-wake interrupt, a simultaneous reset and interrupt, and a late PLL lock. These expose a leaky wake mask, a wrong priority that reports an interrupt, and a release that does not wait for lock.

// File: rtl/halt_pkg.sv
package halt_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STAB = 2'd2,
    ST_PLLW = 2'd3
  } pwr_state_t;
endpackage

// File: rtl/halt_gate.sv
// Qualifies halt requests and detects wake sources.
module halt_gate #(
  parameter int              NIRQ      = 4,
  parameter logic [NIRQ-1:0] WAKE_MASK = 'b0101
) (
  input  logic            halt_req,
  input  logic            cfg_active_halt,
  input  logic            cfg_awu_en,
  input  logic            cfg_wdg_en,
  input  logic            cfg_wdg_halt_ok,
  input  logic            reset_req,
  input  logic [NIRQ-1:0] irq_req,
  output logic            go_halt,
  output logic            go_wdg,
  output logic            wake_any,
  output logic            wake_rst,
  output logic [NIRQ-1:0] wake_vec
);
  logic            req_ok;
  logic [NIRQ-1:0] masked;

  always_comb begin
    req_ok   = halt_req && !cfg_active_halt && !cfg_awu_en;
    go_wdg   = req_ok && cfg_wdg_en && !cfg_wdg_halt_ok;
    go_halt  = req_ok && !go_wdg;
    masked   = irq_req & WAKE_MASK;
    wake_rst = reset_req;
    wake_any = reset_req || (|masked);
    // reset wins over interrupts (R9)
    wake_vec = reset_req ? '0 : masked;
  end
endmodule

// File: rtl/halt_stab_timer.sv
// Stabilization counter on the oscillator clock; one-cycle done pulse.
module halt_stab_timer #(
  parameter int SHORT_DLY = 256,
  parameter int LONG_DLY  = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic long_sel,
  output logic done
);
  localparam int MAXD = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
  localparam int CW   = $clog2(MAXD) + 1;
  // load value leaves one cycle for done and one for the state change
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_DLY - 2);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_DLY - 2);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cnt <= long_sel ? LONG_LD : SHORT_LD;
        run <= 1'b1;
      end else if (run) begin
        if (cnt == '0) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r6_done_needs_run: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(run));

  initial begin
    a_r6_min_delay: assert (SHORT_DLY >= 2 && LONG_DLY >= 2);
  end
endmodule

// File: rtl/halt_pwr_seq.sv
module halt_pwr_seq
  import halt_pkg::*;
#(
  parameter int              NIRQ      = 4,
  parameter logic [NIRQ-1:0] WAKE_MASK = 'b0101,
  parameter int              SHORT_DLY = 256,
  parameter int              LONG_DLY  = 4096
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            halt_req,
  input  logic            cfg_active_halt,
  input  logic            cfg_awu_en,
  input  logic            cfg_wdg_en,
  input  logic            cfg_wdg_halt_ok,
  input  logic            cfg_long_dly,
  input  logic            cfg_pll_en,
  input  logic            pll_locked,
  input  logic            reset_req,
  input  logic [NIRQ-1:0] irq_req,
  output logic            osc_en,
  output logic            cpu_clk_en,
  output logic            per_clk_en,
  output logic            imask_clr,
  output logic            wdg_rst,
  output logic            wake_valid,
  output logic            wake_is_reset,
  output logic [NIRQ-1:0] wake_irq
);
  pwr_state_t      state, nxt;
  logic            go_halt, go_wdg, wake_any, wake_rst;
  logic [NIRQ-1:0] wake_vec;
  logic            start, tdone;

  halt_gate #(.NIRQ(NIRQ), .WAKE_MASK(WAKE_MASK)) u_gate (
    .halt_req        (halt_req),
    .cfg_active_halt (cfg_active_halt),
    .cfg_awu_en      (cfg_awu_en),
    .cfg_wdg_en      (cfg_wdg_en),
    .cfg_wdg_halt_ok (cfg_wdg_halt_ok),
    .reset_req       (reset_req),
    .irq_req         (irq_req),
    .go_halt         (go_halt),
    .go_wdg          (go_wdg),
    .wake_any        (wake_any),
    .wake_rst        (wake_rst),
    .wake_vec        (wake_vec)
  );

  halt_stab_timer #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .long_sel (cfg_long_dly),
    .done     (tdone)
  );

  always_comb begin
    start = (state == ST_HALT) && wake_any;
    nxt   = state;
    unique case (state)
      ST_RUN:  if (go_halt) nxt = ST_HALT;
      ST_HALT: if (wake_any) nxt = ST_STAB;
      ST_STAB: if (tdone) nxt = (!cfg_pll_en || pll_locked) ? ST_RUN : ST_PLLW;
      ST_PLLW: if (pll_locked) nxt = ST_RUN;
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_RUN;
      osc_en        <= 1'b1;
      cpu_clk_en    <= 1'b1;
      per_clk_en    <= 1'b1;
      imask_clr     <= 1'b0;
      wdg_rst       <= 1'b0;
      wake_valid    <= 1'b0;
      wake_is_reset <= 1'b0;
      wake_irq      <= '0;
    end else begin
      state      <= nxt;
      osc_en     <= (nxt != ST_HALT);
      cpu_clk_en <= (nxt == ST_RUN);
      per_clk_en <= (nxt == ST_RUN);
      imask_clr  <= (nxt == ST_HALT);
      wdg_rst    <= (state == ST_RUN) && go_wdg;
      wake_valid <= (state != ST_RUN) && (nxt == ST_RUN);
      if (start) begin
        wake_is_reset <= wake_rst;
        wake_irq      <= wake_vec;
      end
    end
  end

  a_r1_blocked_ignored: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && halt_req && (cfg_active_halt || cfg_awu_en)) |=> (osc_en && !wdg_rst));
  a_r2_wdg_keeps_running: assert property (@(posedge clk) disable iff (rst)
    wdg_rst |-> (osc_en && cpu_clk_en && per_clk_en));
  a_r3_mask_while_off: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> imask_clr);
  a_r5_stay_halted: assert property (@(posedge clk) disable iff (rst)
    (!osc_en && !reset_req && ((irq_req & WAKE_MASK) == '0)) |=> !osc_en);
  a_r8_release_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(per_clk_en) |-> wake_valid);
  a_r7_pll_hold: assert property (@(posedge clk) disable iff (rst)
    (cfg_pll_en && !pll_locked && !per_clk_en) |=> !per_clk_en);
  a_r9_reset_priority: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_en) |-> (wake_is_reset == $past(reset_req)));
endmodule

// File: tb/halt_pwr_seq_test.sv
module halt_pwr_seq_test;
  localparam int NIRQ = 4;

  logic clk = 1'b0;
  logic rst;
  logic halt_req, cfg_active_halt, cfg_awu_en, cfg_wdg_en, cfg_wdg_halt_ok;
  logic cfg_long_dly, cfg_pll_en, pll_locked, reset_req;
  logic [NIRQ-1:0] irq_req;
  logic osc_en, cpu_clk_en, per_clk_en, imask_clr, wdg_rst, wake_valid, wake_is_reset;
  logic [NIRQ-1:0] wake_irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  halt_pwr_seq #(.NIRQ(NIRQ)) uut (
    .clk(clk), .rst(rst), .halt_req(halt_req),
    .cfg_active_halt(cfg_active_halt), .cfg_awu_en(cfg_awu_en),
    .cfg_wdg_en(cfg_wdg_en), .cfg_wdg_halt_ok(cfg_wdg_halt_ok),
    .cfg_long_dly(cfg_long_dly), .cfg_pll_en(cfg_pll_en), .pll_locked(pll_locked),
    .reset_req(reset_req), .irq_req(irq_req),
    .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .imask_clr(imask_clr), .wdg_rst(wdg_rst), .wake_valid(wake_valid),
    .wake_is_reset(wake_is_reset), .wake_irq(wake_irq)
  );

  // {active, awu, wdg_en, wdg_ok, expect_halt, expect_wdg}
  localparam logic [5:0] VEC [0:5] = '{
    6'b0000_10, 6'b1000_00, 6'b0100_00, 6'b0010_01, 6'b0011_10, 6'b1110_00
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wait_release(output int n);
    n = 0;
    while (!per_clk_en && n < 10000) begin
      step();
      n++;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    rst = 1'b1; halt_req = 0; cfg_active_halt = 0; cfg_awu_en = 0;
    cfg_wdg_en = 0; cfg_wdg_halt_ok = 0; cfg_long_dly = 0; cfg_pll_en = 0;
    pll_locked = 0; reset_req = 0; irq_req = '0;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk(osc_en && cpu_clk_en && per_clk_en, "R1 reset clocks", {osc_en, cpu_clk_en, per_clk_en}, 7);
    chk(!imask_clr && !wdg_rst && !wake_valid, "R1 reset flags", {imask_clr, wdg_rst, wake_valid}, 0);

    // table of halt qualification cases
    for (int i = 0; i < 6; i++) begin
      logic [5:0] v;
      v = VEC[i];
      {cfg_active_halt, cfg_awu_en, cfg_wdg_en, cfg_wdg_halt_ok} = v[5:2];
      halt_req = 1'b1;
      step();
      halt_req = 1'b0;
      chk(osc_en == !v[1], "R1 R3 halt qualify osc_en", osc_en, !v[1]);
      chk(per_clk_en == !v[1], "R3 halt qualify per_clk_en", per_clk_en, !v[1]);
      chk(wdg_rst == v[0], "R2 watchdog pulse", wdg_rst, v[0]);
      if (v[0]) begin
        chk(cpu_clk_en == 1'b1, "R2 cpu stays clocked", cpu_clk_en, 1);
        step();
        chk(wdg_rst == 1'b0, "R2 pulse one cycle", wdg_rst, 0);
      end
      if (v[1]) begin
        chk(imask_clr == 1'b1, "R3 mask cleared", imask_clr, 1);
        reset_req = 1'b1;
        step();
        reset_req = 1'b0;
        chk(osc_en == 1'b1, "R6 osc back after wake", osc_en, 1);
        wait_release(n);
        chk(n == 256, "R6 short delay", n, 256);
        chk(wake_valid && wake_is_reset, "R8 reset cause", {wake_valid, wake_is_reset}, 3);
      end
    end
    cfg_active_halt = 0; cfg_awu_en = 0; cfg_wdg_en = 0; cfg_wdg_halt_ok = 0;

    // R5 non-wake interrupts ignored, then interrupt wake with R8 cause
    halt_req = 1'b1; step(); halt_req = 1'b0;
    irq_req = 4'b1010;
    repeat (5) step();
    chk(osc_en == 1'b0, "R5 masked-out irq ignored", osc_en, 0);
    chk(imask_clr == 1'b1, "R3 mask held in halt", imask_clr, 1);
    irq_req = 4'b1110;
    step();
    irq_req = '0;
    chk(osc_en == 1'b1 && per_clk_en == 1'b0, "R6 osc on, peripherals gated", {osc_en, per_clk_en}, 2);
    wait_release(n);
    chk(n == 256, "R6 irq wake delay", n, 256);
    chk(wake_valid && !wake_is_reset, "R8 irq cause", {wake_valid, wake_is_reset}, 2);
    chk(wake_irq == 4'b0100, "R8 wake vector", wake_irq, 4);
    step();
    chk(wake_valid == 1'b0, "R8 wake_valid one cycle", wake_valid, 0);

    // R4 pending interrupt at entry
    irq_req = 4'b0001; halt_req = 1'b1;
    step();
    halt_req = 1'b0;
    chk(osc_en == 1'b0, "R4 halt entered", osc_en, 0);
    step();
    irq_req = '0;
    chk(osc_en == 1'b1, "R4 single halted cycle", osc_en, 1);
    wait_release(n);
    chk(wake_irq == 4'b0001, "R8 pending cause", wake_irq, 1);

    // R9 reset and interrupt together, long delay R6
    cfg_long_dly = 1'b1;
    halt_req = 1'b1; step(); halt_req = 1'b0;
    reset_req = 1'b1; irq_req = 4'b0101;
    step();
    reset_req = 1'b0; irq_req = '0;
    wait_release(n);
    chk(n == 4096, "R6 long delay", n, 4096);
    chk(wake_is_reset == 1'b1 && wake_irq == '0, "R9 reset priority", {wake_is_reset, wake_irq}, 16);
    cfg_long_dly = 1'b0;

    // R7 PLL lock wait
    cfg_pll_en = 1'b1; pll_locked = 1'b0;
    halt_req = 1'b1; step(); halt_req = 1'b0;
    irq_req = 4'b0100; step(); irq_req = '0;
    repeat (300) step();
    chk(per_clk_en == 1'b0, "R7 held without lock", per_clk_en, 0);
    pll_locked = 1'b1;
    step();
    chk(per_clk_en == 1'b1 && wake_valid, "R7 release after lock", {per_clk_en, wake_valid}, 3);

    // R7 lock already present: normal delay
    halt_req = 1'b1; step(); halt_req = 1'b0;
    reset_req = 1'b1; step(); reset_req = 1'b0;
    wait_release(n);
    chk(n == 256, "R7 locked PLL no extra wait", n, 256);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule